// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides when an outside master may take the external memory bus away from the internal bus controller. The outside master asks for the bus by pulling an active-low request line. That line is asynchronous, so it passes through a two-stage synchronizer first. Once the request is seen, the arbiter stops the controller from starting new cycles. It lets any cycle already in progress finish. It then drives an active-low acknowledge. For as long as the acknowledge is low, the pad logic floats the address/data lines and holds the control strobes weakly at their inactive levels.

While the bus is lent out, the internal controller may still have external work waiting. The arbiter reports that demand to the outside master on an active-low bus-request output. When the outside master lets go of the request line, the acknowledge rises first. The lines stay floated and weakly driven for a programmable restore window (`RESTORE_CYC` cycles) after that. Only then does the controller get the bus back and may start cycles again. All outputs change on the rising edge of `clk`, which stands for the clock-output edge the pins are timed from.

The controller in `hold_arb_pkg::hold_state_t` has four states:
- **ST_OWN**: the internal controller owns the bus. On a synchronized request it moves to ST_HELD if no cycle is active, or to ST_DRAIN if one is.
- **ST_DRAIN**: waits for the active cycle to end, then moves to ST_HELD. If the request goes away first, it moves back to ST_OWN.
- **ST_HELD**: the acknowledge is low. When the synchronized request drops, it moves to ST_RESTORE.
- **ST_RESTORE**: the acknowledge is high and the lines are still floated. When the restore timer expires, it moves to ST_OWN.

Top module: `hold_arbiter`

## Requirements
- R1: After reset, with `hold_req_n` high: `hold_ack_n`=1, `bus_req_n`=1, `addr_float`=0, `ctl_weak`=0 and `cyc_allow`=1.
- R2: A falling edge on `hold_req_n` is synchronized through two flops. When no cycle is active, `hold_ack_n` goes low on the third rising edge after the change, and not before.
- R3: `hold_ack_n` never falls while `cyc_active` was sampled high at that edge. A request that arrives during a cycle is granted on the first edge at which `cyc_active` is sampled low.
- R4: Whenever `hold_ack_n` is low, `addr_float`=1, `ctl_weak`=1 and `cyc_allow`=0.
- R5: `bus_req_n` is low only while `hold_ack_n` is low, and only when `cyc_pending` was high at the edge that updated it. It returns high on the same edge on which `hold_ack_n` rises.
- R6: When `hold_req_n` rises, `hold_ack_n` rises on the third rising edge. `addr_float` and `ctl_weak` then stay at 1 for exactly `RESTORE_CYC` cycles with `hold_ack_n` high, and fall together.
- R7: `cyc_allow` is 0 from the cycle in which the synchronized request is present. It stays 0 until the bus is back in ST_OWN with no request, so no new cycle can start once a hold is seen.
- R8: If the request is withdrawn while the arbiter is waiting for a cycle to end, the arbiter returns to owning the bus. `hold_ack_n` never goes low and `cyc_allow` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| cyc_active | input | 1 | Internal controller has a bus cycle in progress |
| cyc_pending | input | 1 | Internal controller has an external cycle waiting |
| hold_ack_n | output | 1 | Active-low grant of the bus to the outside master |
| bus_req_n | output | 1 | Active-low flag of internal demand during the hold |
| addr_float | output | 1 | Float the address/data lines |
| ctl_weak | output | 1 | Drive the control strobes weakly inactive |
| cyc_allow | output | 1 | Internal controller may start a new bus cycle |

## Verification
Two events can land on the same edge: the synchronized request appearing, and the internal controller ending its cycle. The bench lowers `cyc_active` at exactly the edge where the second synchronizer stage picks up the request. It then expects the grant one edge later, with no stray ST_DRAIN visit and no early acknowledge. A second overlap is the hold being released while `cyc_pending` is still high. In that case `bus_req_n` must rise on the same edge as `hold_ack_n`, never after it.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_HELD    = 2'd2,
        ST_RESTORE = 2'd3
    } hold_state_t;
endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic req
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din_n};
    end

    assign req = ~q[STAGES-1];
endmodule

// File: rtl/hold_restore_timer.sv
module hold_restore_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESTORE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic cyc_active,
    input  logic cyc_pending,
    output logic hold_ack_n,
    output logic bus_req_n,
    output logic addr_float,
    output logic ctl_weak,
    output logic cyc_allow
);
    hold_state_t state, nxt;
    logic        req_s;
    logic        restore_done;

    hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_n (hold_req_n),
        .req   (req_s)
    );

    hold_restore_timer #(.CYCLES(RESTORE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_RESTORE),
        .expired (restore_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWN: begin
                if (req_s) nxt = cyc_active ? ST_DRAIN : ST_HELD;
            end
            ST_DRAIN: begin
                if (!req_s)          nxt = ST_OWN;
                else if (!cyc_active) nxt = ST_HELD;
            end
            ST_HELD: begin
                if (!req_s) nxt = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (restore_done) nxt = ST_OWN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OWN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_ack_n <= 1'b1;
            bus_req_n  <= 1'b1;
            addr_float <= 1'b0;
            ctl_weak   <= 1'b0;
        end else begin
            hold_ack_n <= (nxt != ST_HELD);
            bus_req_n  <= !((nxt == ST_HELD) && cyc_pending);
            addr_float <= (nxt == ST_HELD) || (nxt == ST_RESTORE);
            ctl_weak   <= (nxt == ST_HELD) || (nxt == ST_RESTORE);
        end
    end

    assign cyc_allow = (state == ST_OWN) && !req_s;

    AST_ACK_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (addr_float && ctl_weak && !cyc_allow)); // R4
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> !$past(cyc_active)); // R3
    AST_BREQ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> !hold_ack_n); // R5
    AST_ACK_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_float) |-> ($past(hold_ack_n) && hold_ack_n)); // R6
    AST_ALLOW_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_allow |-> (hold_ack_n && !addr_float && !ctl_weak)); // R7
endmodule

// File: tb/hold_arbiter_bench.sv
module hold_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1;
    logic cyc_active = 1'b0;
    logic cyc_pending = 1'b0;
    logic hold_ack_n, bus_req_n, addr_float, ctl_weak, cyc_allow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hold_arbiter #(.SYNC_STAGES(2), .RESTORE_CYC(2)) u_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n),
        .cyc_active(cyc_active), .cyc_pending(cyc_pending),
        .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n),
        .addr_float(addr_float), .ctl_weak(ctl_weak), .cyc_allow(cyc_allow)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R1", "ack", hold_ack_n, 1'b1);
        chk("R1", "breq", bus_req_n, 1'b1);
        chk("R1", "float", addr_float, 1'b0);
        chk("R1", "weak", ctl_weak, 1'b0);
        chk("R1", "allow", cyc_allow, 1'b1);
    endtask

    task automatic t_grant_idle_release;
        hold_req_n = 1'b0;
        tick(2);
        chk("R2", "ack early", hold_ack_n, 1'b1);
        chk("R7", "allow after sync", cyc_allow, 1'b0);
        tick(1);
        chk("R2", "ack third edge", hold_ack_n, 1'b0);
        chk("R4", "float", addr_float, 1'b1);
        chk("R4", "weak", ctl_weak, 1'b1);
        chk("R4", "allow", cyc_allow, 1'b0);
        chk("R5", "breq idle", bus_req_n, 1'b1);
        cyc_pending = 1'b1;
        tick(1);
        chk("R5", "breq demand", bus_req_n, 1'b0);
        hold_req_n = 1'b1;
        tick(2);
        chk("R6", "ack still low", hold_ack_n, 1'b0);
        tick(1);
        chk("R6", "ack high", hold_ack_n, 1'b1);
        chk("R5", "breq with ack", bus_req_n, 1'b1);
        chk("R6", "float kept", addr_float, 1'b1);
        tick(1);
        chk("R6", "float kept 2", addr_float, 1'b1);
        chk("R6", "weak kept 2", ctl_weak, 1'b1);
        tick(1);
        chk("R6", "float off", addr_float, 1'b0);
        chk("R6", "weak off", ctl_weak, 1'b0);
        chk("R7", "allow back", cyc_allow, 1'b1);
        cyc_pending = 1'b0;
        tick(2);
    endtask

    task automatic t_grant_busy;
        cyc_active = 1'b1;
        hold_req_n = 1'b0;
        tick(3);
        chk("R3", "no ack busy", hold_ack_n, 1'b1);
        chk("R7", "allow busy", cyc_allow, 1'b0);
        tick(3);
        chk("R3", "no ack busy 2", hold_ack_n, 1'b1);
        cyc_active = 1'b0;
        tick(1);
        chk("R3", "ack after cycle", hold_ack_n, 1'b0);
        hold_req_n = 1'b1;
        tick(3);
        chk("R6", "ack release", hold_ack_n, 1'b1);
        tick(2);
        chk("R6", "float off", addr_float, 1'b0);
        tick(2);
    endtask

    task automatic t_withdraw;
        bit seen_low = 1'b0;
        cyc_active = 1'b1;
        hold_req_n = 1'b0;
        tick(3);
        hold_req_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            if (hold_ack_n === 1'b0) seen_low = 1'b1;
        end
        chk("R8", "allow back", cyc_allow, 1'b1);
        cyc_active = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (hold_ack_n === 1'b0) seen_low = 1'b1;
        end
        chk("R8", "never granted", seen_low, 1'b0);
        chk("R8", "no float", addr_float, 1'b0);
    endtask

    task automatic t_collision;
        cyc_active = 1'b1;
        hold_req_n = 1'b0;
        tick(1);
        cyc_active = 1'b0;
        tick(1);
        chk("R3", "collision no early ack", hold_ack_n, 1'b1);
        tick(1);
        chk("R3", "collision grant", hold_ack_n, 1'b0);
        cyc_pending = 1'b1;
        hold_req_n = 1'b1;
        tick(1);
        chk("R5", "breq while held", bus_req_n, 1'b0);
        tick(2);
        chk("R5", "breq drops with ack", bus_req_n, 1'b1);
        chk("R6", "ack up", hold_ack_n, 1'b1);
        cyc_pending = 1'b0;
        tick(3);
        chk("R1", "idle again", cyc_allow, 1'b1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_grant_idle_release();
        t_grant_busy();
        t_withdraw();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule